// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block takes a stereo serial audio stream on three wires and turns it into parallel samples. The wires are a bit clock, a frame sync and a data line. It feeds a downstream S/PDIF encoder. All logic runs on one system clock. The bit clock and frame sync are oversampled, so each half of the bit clock must last at least one system clock.

A rising bit-clock edge is detected from a registered copy of the bit clock. On that edge the frame sync and the data bit are sampled. A change of frame-sync level marks the start of a channel, and a slot counter then counts the bit positions inside the channel. Static configuration inputs select the data alignment (left-justified, I2S or right-justified) and the word width (16, 18, 20 or 24 bits). Together they fix the slot in which the most significant bit arrives.

Each finished word is presented left-aligned in a 24-bit field. A channel flag and a one-cycle valid strobe go with it. The word is released at the frame-sync transition that closes its channel.

Top module: `serial_audio_rx`

## Requirements
- R1: The frame sync and data inputs are sampled only at a system clock edge where `sck_i` is high and was low at the previous system clock edge. Between such edges, changes on these inputs have no effect.
- R2: A frame-sync level of 1 marks a left word and 0 marks a right word. `left_o` reports the level that was held during the word being delivered.
- R3: With `fmt_sel`=0 (left-justified), the MSB is taken in slot 0. Slot 0 is the first sampled bit at which the frame-sync level differs from the previous sample.
- R4: With `fmt_sel`=1 (I2S), the MSB is taken in slot 1.
- R5: With `fmt_sel`=2 (right-justified), the MSB is taken in slot 32-W, where W is the word width. This gives offsets of 16, 14, 12 and 8, and the LSB falls in slot 31 of a 32-slot channel.
- R6: `wsel` encodes the word width W: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Bits arrive MSB first.
- R7: The word appears in `sample_o[23:24-W]`, and `sample_o[23-W:0]` is zero.
- R8: `valid_o` is high for exactly one system clock. It rises in the cycle after the sampled bit-clock edge that sees a frame-sync change, and it delivers the word of the channel that has just ended.
- R9: Data bits in slots outside the active word window do not affect the delivered sample.
- R10: After reset `valid_o`, `sample_o` and `left_o` are 0. The channel that follows the first frame-sync transition is the first one delivered, so bits received before that transition are discarded.
- R11: `fmt_sel`=3 behaves as left-justified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Alignment select: 0 left-justified, 1 I2S, 2 right-justified, 3 left-justified |
| wsel | input | 2 | Word width select: 0=16, 1=18, 2=20, 3=24 bits |
| sck_i | input | 1 | Serial bit clock, synchronous to clk |
| fs_i | input | 1 | Frame sync, high marks the left channel |
| sd_i | input | 1 | Serial data, MSB first |
| sample_o | output | 24 | Received word, left-aligned |
| left_o | output | 1 | 1 when the delivered word is a left-channel word |
| valid_o | output | 1 | One-cycle strobe for sample_o and left_o |

## Verification
A wrong slot counter or a wrong start offset shifts the capture window. The next delivered word then comes out shifted or mixed with junk bits, visibly so within one channel of about 64 system clocks, because the bench drives random bits into every slot outside the window. A wrong edge or arming state shows up as a strobe that is missing, duplicated or misplaced. The bench checks the strobe on every bit slot, so such an error is reported within two system clocks of the frame-sync change. A wrong channel flag or an unmasked low bit shows on the first delivered word.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

    localparam int OUT_W    = 24;
    localparam int CH_SLOTS = 32;
    localparam int SLOT_W   = $clog2(2 * CH_SLOTS);
    localparam int POS_W    = $clog2(OUT_W);

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_ALT = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [OUT_W-1:0] word;
        logic             left;
    } audio_word_t;

    function automatic logic [SLOT_W-1:0] word_bits(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return SLOT_W'(16);
            2'd1:    return SLOT_W'(18);
            2'd2:    return SLOT_W'(20);
            default: return SLOT_W'(24);
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] first_slot(input fmt_e fmt, input logic [1:0] wsel);
        case (fmt)
            FMT_I2S: return SLOT_W'(1);
            FMT_RJ:  return SLOT_W'(CH_SLOTS) - word_bits(wsel);
            default: return '0;
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] low_mask(input logic [1:0] wsel);
        return {OUT_W{1'b1}} >> word_bits(wsel);
    endfunction

endpackage

// File: rtl/serial_audio_edge_det.sv
module serial_audio_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sck_i,
    input  logic fs_i,
    output logic sck_rise,
    output logic fs_change,
    output logic fs_held
);
    logic sck_q;
    logic seen_q;

    assign sck_rise  = sck_i & ~sck_q;
    assign fs_change = sck_rise & seen_q & (fs_i != fs_held);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            seen_q  <= 1'b0;
            fs_held <= 1'b0;
        end else begin
            sck_q <= sck_i;
            if (sck_rise) begin
                seen_q  <= 1'b1;
                fs_held <= fs_i;
            end
        end
    end

    // R1: a frame-sync change is reported only at a sampled bit-clock rise
    assert_change_on_rise_R1: assert property (@(posedge clk) disable iff (rst)
        fs_change |-> (sck_i && !sck_q));

endmodule

// File: rtl/serial_audio_capture.sv
module serial_audio_capture
    import serial_audio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              fs_change,
    input  logic              fs_held,
    input  logic              sd_i,
    input  logic [SLOT_W-1:0] start_slot,
    input  logic [SLOT_W-1:0] nbits,
    output audio_word_t       out_word,
    output logic              out_valid
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] slot_now;
    logic [SLOT_W-1:0] pos;
    logic [OUT_W-1:0]  acc_q, acc_d;
    logic              armed_q;
    logic              in_win;

    assign slot_now = fs_change ? '0 : cnt_q;
    assign pos      = slot_now - start_slot;
    assign in_win   = (slot_now >= start_slot) && (pos < nbits);

    always_comb begin
        acc_d = fs_change ? '0 : acc_q;
        if (in_win)
            acc_d[POS_W'(OUT_W - 1) - pos[POS_W-1:0]] = sd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            acc_q     <= '0;
            armed_q   <= 1'b0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (sck_rise) begin
                acc_q <= acc_d;
                if (fs_change)
                    cnt_q <= SLOT_W'(1);
                else if (cnt_q != SLOT_MAX)
                    cnt_q <= cnt_q + 1'b1;
                if (fs_change) begin
                    armed_q <= 1'b1;
                    if (armed_q) begin
                        out_word.word <= acc_q;
                        out_word.left <= fs_held;
                        out_valid     <= 1'b1;
                    end
                end
            end
        end
    end

    // R3: the slot count restarts at a frame-sync change
    assert_slot_restart_R3: assert property (@(posedge clk) disable iff (rst)
        fs_change |=> (cnt_q == SLOT_W'(1)));

    // R8: the strobe lasts a single cycle
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import serial_audio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_sel,
    input  logic [1:0]        wsel,
    input  logic              sck_i,
    input  logic              fs_i,
    input  logic              sd_i,
    output logic [OUT_W-1:0]  sample_o,
    output logic              left_o,
    output logic              valid_o
);
    logic        sck_rise;
    logic        fs_change;
    logic        fs_held;
    audio_word_t word;
    fmt_e        fmt;

    assign fmt = fmt_e'(fmt_sel);

    serial_audio_edge_det u_edge (
        .clk       (clk),
        .rst       (rst),
        .sck_i     (sck_i),
        .fs_i      (fs_i),
        .sck_rise  (sck_rise),
        .fs_change (fs_change),
        .fs_held   (fs_held)
    );

    serial_audio_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .sck_rise   (sck_rise),
        .fs_change  (fs_change),
        .fs_held    (fs_held),
        .sd_i       (sd_i),
        .start_slot (first_slot(fmt, wsel)),
        .nbits      (word_bits(wsel)),
        .out_word   (word),
        .out_valid  (valid_o)
    );

    assign sample_o = word.word;
    assign left_o   = word.left;

    // R7: bits below the word width are zero on every delivered sample
    assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ((sample_o & low_mask(wsel)) == '0));

    // R8: a strobe follows a sampled frame-sync change
    assert_strobe_after_change_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(fs_change));

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'd0;
    logic [1:0]  wsel = 2'd0;
    logic        sck_i = 1'b0;
    logic        fs_i = 1'b0;
    logic        sd_i = 1'b0;
    logic [23:0] sample_o;
    logic        left_o;
    logic        valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wsel(wsel),
        .sck_i(sck_i), .fs_i(fs_i), .sd_i(sd_i),
        .sample_o(sample_o), .left_o(left_o), .valid_o(valid_o)
    );

    // bench model state
    bit          prev_fs;
    bit          have_pend;
    logic [23:0] pend_word;
    bit          pend_left;

    function automatic int bits_of(input logic [1:0] w);
        case (w)
            2'd0: return 16;
            2'd1: return 18;
            2'd2: return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int start_of(input logic [1:0] f, input logic [1:0] w);
        if (f == 2'd1) return 1;
        if (f == 2'd2) return 32 - bits_of(w);
        return 0;
    endfunction

    function automatic string fmt_req(input logic [1:0] f);
        if (f == 2'd1) return "R4";
        if (f == 2'd2) return "R5";
        if (f == 2'd3) return "R11";
        return "R3";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bit slot: drive low phase, rise, then check strobe at next falling edge
    task automatic drive_slot(input bit fs, input bit sd);
        bit edge_seen;
        edge_seen = (fs != prev_fs);
        sck_i = 1'b0; fs_i = fs; sd_i = sd;
        @(negedge clk);
        sck_i = 1'b1;
        @(negedge clk);
        if (edge_seen && have_pend) begin
            check(valid_o == 1'b1, "R8", {31'd0, valid_o}, 32'd1);
            check(sample_o == pend_word, {fmt_req(fmt_sel), " R6 R7 R9"}, {8'd0, sample_o}, {8'd0, pend_word});
            check(left_o == pend_left, "R2", {31'd0, left_o}, {31'd0, pend_left});
            have_pend = 1'b0;
        end else begin
            check(valid_o == 1'b0, "R8 R10", {31'd0, valid_o}, 32'd0);
        end
        prev_fs = fs;
    endtask

    task automatic run_channel(input bit fs, input logic [23:0] w);
        int st, nb;
        logic [23:0] m;
        st = start_of(fmt_sel, wsel);
        nb = bits_of(wsel);
        for (int s = 0; s < 32; s++) begin
            if (s >= st && s < st + nb)
                drive_slot(fs, w[23 - (s - st)]);
            else
                drive_slot(fs, 1'($urandom));
        end
        m = 24'hFFFFFF << (24 - nb);
        pend_word = w & m;
        pend_left = fs;
        have_pend = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1; sck_i = 1'b0; fs_i = 1'b0; sd_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0 && sample_o == 24'd0 && left_o == 1'b0, "R10",
              {7'd0, valid_o, sample_o}, 32'd0);
        have_pend = 1'b0;
        prev_fs = 1'b0;
    endtask

    task automatic run_scenario(input logic [1:0] f, input logic [1:0] w, input int nch);
        fmt_sel = f; wsel = w;
        do_reset();
        // partial garbage before first transition: discarded (R10)
        for (int i = 0; i < 7; i++) drive_slot(1'b0, 1'b1);
        for (int c = 0; c < nch; c++) begin
            logic [23:0] word;
            word = 24'($urandom);
            if (c == 0) word = 24'hFFFFFF;
            if (c == 1) word = 24'h000000;
            if (c == 2) word = 24'h800001;
            run_channel(~c[0], word);
        end
        drive_slot(~prev_fs, 1'b0);
        // bit-clock high held: extra system clocks must not create strobes (R1)
        repeat (4) @(negedge clk);
        check(valid_o == 1'b0, "R1", {31'd0, valid_o}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int f = 0; f < 4; f++)
            for (int w = 0; w < 4; w++)
                run_scenario(2'(f), 2'(w), 6);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule